// File: doc/BRIEF.md
# Step/Direction Stepper Phase Translator

This block converts step and direction commands into on/off controls for the four phase switches of a two-phase unipolar stepper motor. A motion controller pulses `step_in`. On each accepted rising edge the block moves an internal phase index by one position, forward or backward. The index then decodes into the winding pattern. Full-step operation walks a four-position cycle with two windings always on. Half-step operation walks an eight-position cycle that alternates between two windings and one winding.

Every asynchronous input passes through a two-stage synchroniser. A step edge counts only after `step_in` has stayed high for `MIN_HIGH` clocks. The direction and mode are captured at the rising edge of the pulse. An enable input blanks the outputs while the index keeps counting. A translator reset and a power-down input return the index to the origin. Two protection flags force the outputs off and pull the alarm low. An active-low origin flag marks the initial energising pattern.

Top module: `stepper_phase_xlat`

## Requirements
- R1: Each qualified rising edge of `step_in` moves the phase index by exactly one position. A falling edge, and any time `step_in` stays high after acceptance, leave the index unchanged.
- R2: A high pulse on `step_in` that lasts fewer than `MIN_HIGH` synchronised clocks is ignored. One that lasts `MIN_HIGH` clocks or longer is accepted once.
- R3: `dir_in` and `half_in` are captured in the clock cycle in which the synchronised step rises. A change during the qualification window has no effect on that step. `dir_in`=0 means forward and `dir_in`=1 means reverse.
- R4: With `half_in`=0, forward steps run 1A+2A, 1B+2A, 1B+2B, 1A+2B and then wrap. Reverse runs the same cycle backwards. From a single-winding position, a full step moves one half position, to the nearest two-winding position in the step direction.
- R5: With `half_in`=1, forward steps run 1A+2A, 2A, 1B+2A, 1B, 1B+2B, 2B, 1A+2B, 1A and then wrap (eight positions). Reverse runs the same cycle backwards.
- R6: While `xlat_rst_n` is low, the index returns to the origin, all four outputs are off and step edges are ignored. When it goes high, 1A+2A is driven.
- R7: While `pwr_n` is low, the index is held at the origin, all outputs are off and `origin_n` is low.
- R8: While `enable` is low, `phase_on` is 4'b0000, but accepted steps still move the index. When `enable` returns high, the pattern of the current position is driven.
- R9: `origin_n` is 0 exactly when the index is at the 1A+2A origin position, and 1 otherwise.
- R10: While `fault_uv` or `fault_ot` is high, `phase_on` is 4'b0000 and `alarm_n` is 0. The index keeps following steps. When both faults clear, `alarm_n` returns to 1 and the outputs resume.
- R11: While `rst` is high and just after it falls, `phase_on` is 4'b0101 (1A+2A), `origin_n` is 0 and `alarm_n` is 1.
- R12: `phase_on` bit 0 is 1A, bit 1 is 1B, bit 2 is 2A and bit 3 is 2B. The two halves of one winding (bits 0 and 1, or bits 2 and 3) are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| step_in | input | 1 | Step pulse, asynchronous |
| dir_in | input | 1 | Direction: 0 forward, 1 reverse |
| half_in | input | 1 | Mode: 0 full step, 1 half step |
| enable | input | 1 | 1 drives phases, 0 blanks them |
| xlat_rst_n | input | 1 | Active-low translator reset |
| pwr_n | input | 1 | Active-low power-down |
| fault_uv | input | 1 | Undervoltage fault flag |
| fault_ot | input | 1 | Overtemperature fault flag |
| phase_on | output | 4 | Phase switch controls {2B,2A,1B,1A} |
| origin_n | output | 1 | Low at the origin position |
| alarm_n | output | 1 | Low while a fault is present |

## Verification
The hardest states to reach from the ports are the ones where modes interact. One is a full step taken from a single-winding position left by earlier half steps. Another is a step taken while the outputs are blanked by enable or by a fault, whose effect only shows once they clear. The random stimulus mixes half and full steps in both directions with enable, fault, reset and power-down events, so these orderings arise on their own. Directed cases cover the remaining corners: a direction flip inside the qualification window, a pulse one clock too short, and a step attempted while the translator reset is held.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef struct packed {
    logic step;
    logic dir;
    logic half;
    logic en;
    logic trst_n;
    logic pd_n;
    logic uv;
    logic ot;
  } stx_in_t;

  localparam int STX_IN_W = $bits(stx_in_t);

  // Idle values: the active-low controls and enable sit at 1 so the
  // power-on pattern appears without a blank gap after reset.
  localparam stx_in_t STX_IN_IDLE = '{step: 1'b0, dir: 1'b0, half: 1'b0,
                                      en: 1'b1, trst_n: 1'b1, pd_n: 1'b1,
                                      uv: 1'b0, ot: 1'b0};

  localparam int IDX_W = 3;

  // Phase bit order {2B,2A,1B,1A}; even positions have two windings on.
  function automatic logic [3:0] stx_decode(input logic [IDX_W-1:0] idx);
    logic [3:0] p;
    case (idx)
      3'd0:    p = 4'b0101;
      3'd1:    p = 4'b0100;
      3'd2:    p = 4'b0110;
      3'd3:    p = 4'b0010;
      3'd4:    p = 4'b1010;
      3'd5:    p = 4'b1000;
      3'd6:    p = 4'b1001;
      default: p = 4'b0001;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/stx_sync.sv
module stx_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/stx_step_qual.sv
module stx_step_qual #(
  parameter int MIN_HIGH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic step_s,
  input  logic dir_s,
  input  logic half_s,
  output logic acc,
  output logic acc_dir,
  output logic acc_half
);
  localparam int CW = $clog2(MIN_HIGH + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_HIGH - 1);
  localparam logic [CW-1:0] SAT  = CW'(MIN_HIGH);

  logic [CW-1:0] cnt_q;
  logic          dir_q, half_q;
  logic          first;

  assign first    = step_s && (cnt_q == '0);
  assign acc      = step_s && (cnt_q == LAST);
  assign acc_dir  = first ? dir_s  : dir_q;
  assign acc_half = first ? half_s : half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      if (!step_s)           cnt_q <= '0;
      else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
      if (first) begin
        dir_q  <= dir_s;
        half_q <= half_s;
      end
    end
  end
endmodule

// File: rtl/stx_index.sv
module stx_index
  import stx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic             rev,
  input  logic             half,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W-1:0] idx_d
);
  logic [IDX_W-1:0] fwd_n, rev_n;

  always_comb begin
    if (half) begin
      fwd_n = idx_q + 1'b1;
      rev_n = idx_q - 1'b1;
    end else begin
      fwd_n = (idx_q | IDX_W'(1)) + 1'b1;
      rev_n = (idx_q - 1'b1) & ~IDX_W'(1);
    end
    if (clr)      idx_d = '0;
    else if (adv) idx_d = rev ? rev_n : fwd_n;
    else          idx_d = idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= idx_d;
  end
endmodule

// File: rtl/stepper_phase_xlat.sv
module stepper_phase_xlat
  import stx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step_in,
  input  logic       dir_in,
  input  logic       half_in,
  input  logic       enable,
  input  logic       xlat_rst_n,
  input  logic       pwr_n,
  input  logic       fault_uv,
  input  logic       fault_ot,
  output logic [3:0] phase_on,
  output logic       origin_n,
  output logic       alarm_n
);
  stx_in_t          raw, syn;
  logic             step_acc, acc_dir, acc_half;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             en_s, trst_n_s, pd_n_s, fault_s, clr, drive;

  assign raw = '{step: step_in, dir: dir_in, half: half_in, en: enable,
                 trst_n: xlat_rst_n, pd_n: pwr_n, uv: fault_uv, ot: fault_ot};

  stx_sync #(.W(STX_IN_W), .STAGES(SYNC_STAGES), .RST_VAL(STX_IN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  assign en_s     = syn.en;
  assign trst_n_s = syn.trst_n;
  assign pd_n_s   = syn.pd_n;
  assign fault_s  = syn.uv | syn.ot;
  assign clr      = !trst_n_s || !pd_n_s;

  stx_step_qual #(.MIN_HIGH(MIN_HIGH)) u_qual (
    .clk(clk), .rst(rst), .step_s(syn.step), .dir_s(syn.dir), .half_s(syn.half),
    .acc(step_acc), .acc_dir(acc_dir), .acc_half(acc_half)
  );

  stx_index u_idx (
    .clk(clk), .rst(rst), .clr(clr), .adv(step_acc), .rev(acc_dir),
    .half(acc_half), .idx_q(idx_q), .idx_d(idx_d)
  );

  assign drive = en_s && !clr && !fault_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_on <= stx_decode('0);
      origin_n <= 1'b0;
      alarm_n  <= 1'b1;
    end else begin
      phase_on <= drive ? stx_decode(idx_d) : 4'b0000;
      origin_n <= (idx_d != '0);
      alarm_n  <= !fault_s;
    end
  end
endmodule

// File: rtl/stx_checker.sv
module stx_checker
  import stx_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             en_s,
  input logic             trst_n_s,
  input logic             pd_n_s,
  input logic             fault_s,
  input logic             step_acc,
  input logic [IDX_W-1:0] idx_q,
  input logic [3:0]       phase_on,
  input logic             origin_n,
  input logic             alarm_n
);
  assert_single_accept_R2: assert property (@(posedge clk) disable iff (rst)
    step_acc |=> !step_acc);

  assert_index_holds_R1: assert property (@(posedge clk) disable iff (rst)
    (!step_acc && trst_n_s && pd_n_s) |=> $stable(idx_q));

  assert_trst_off_R6: assert property (@(posedge clk) disable iff (rst)
    !trst_n_s |=> (phase_on == 4'b0000 && idx_q == '0));

  assert_pd_origin_R7: assert property (@(posedge clk) disable iff (rst)
    !pd_n_s |=> (phase_on == 4'b0000 && !origin_n));

  assert_enable_blank_R8: assert property (@(posedge clk) disable iff (rst)
    !en_s |=> phase_on == 4'b0000);

  assert_origin_tracks_R9: assert property (@(posedge clk) disable iff (rst)
    !origin_n |-> idx_q == '0);

  assert_fault_off_R10: assert property (@(posedge clk) disable iff (rst)
    fault_s |=> (phase_on == 4'b0000 && !alarm_n));

  assert_no_shoot_R12: assert property (@(posedge clk) disable iff (rst)
    !(phase_on[0] && phase_on[1]) && !(phase_on[2] && phase_on[3]));
endmodule

bind stepper_phase_xlat stx_checker u_chk (
  .clk(clk), .rst(rst), .en_s(en_s), .trst_n_s(trst_n_s), .pd_n_s(pd_n_s),
  .fault_s(fault_s), .step_acc(step_acc), .idx_q(idx_q), .phase_on(phase_on),
  .origin_n(origin_n), .alarm_n(alarm_n)
);

// File: tb/stepper_phase_xlat_bench.sv
module stepper_phase_xlat_bench;
  localparam int MINH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_in = 0, dir_in = 0, half_in = 0, enable = 1;
  logic xlat_rst_n = 1, pwr_n = 1, fault_uv = 0, fault_ot = 0;
  logic [3:0] phase_on;
  logic origin_n, alarm_n;

  int checks = 0, fails = 0;
  int pos = 0;  // model position in half-step units, 0..7

  always #4 clk = ~clk;

  stepper_phase_xlat #(.SYNC_STAGES(2), .MIN_HIGH(MINH)) u_stepper_phase_xlat (
    .clk(clk), .rst(rst), .step_in(step_in), .dir_in(dir_in), .half_in(half_in),
    .enable(enable), .xlat_rst_n(xlat_rst_n), .pwr_n(pwr_n),
    .fault_uv(fault_uv), .fault_ot(fault_ot),
    .phase_on(phase_on), .origin_n(origin_n), .alarm_n(alarm_n)
  );

  // Winding pattern of a half-step position, built from which coils are on.
  function automatic logic [3:0] pattern(input int p);
    logic a1, b1, a2, b2;
    a1 = (p == 7) || (p == 0) || (p == 1) ? (p != 1) : 1'b0;
    a1 = (p == 7) || (p == 0) || (p == 6);
    b1 = (p >= 2) && (p <= 4);
    a2 = (p >= 0) && (p <= 2);
    b2 = (p >= 4) && (p <= 6);
    if (p == 1) a1 = 1'b0;
    if (p == 3) begin a2 = 1'b0; b2 = 1'b0; end
    if (p == 5) b1 = 1'b0;
    if (p == 7) begin a2 = 1'b0; b2 = 1'b0; end
    if (p == 1) b1 = 1'b0;
    return {b2, a2, b1, a1};
  endfunction

  function automatic int next_pos(input int p, input bit rev, input bit half);
    int n;
    if (half) n = rev ? p - 1 : p + 1;
    else if (p % 2 == 0) n = rev ? p - 2 : p + 2;
    else n = rev ? p - 1 : p + 1;
    return (n + 8) % 8;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] exp_ph,
                     input logic exp_org, input logic exp_al);
    checks++;
    if (phase_on !== exp_ph || origin_n !== exp_org || alarm_n !== exp_al) begin
      fails++;
      $display("FAIL %s: phase=%b origin_n=%b alarm_n=%b expected phase=%b origin_n=%b alarm_n=%b",
               req, phase_on, origin_n, alarm_n, exp_ph, exp_org, exp_al);
    end
  endtask

  function automatic logic [3:0] exp_out();
    if (enable && xlat_rst_n && pwr_n && !fault_uv && !fault_ot) return pattern(pos);
    return 4'b0000;
  endfunction

  task automatic chk_model(input string req);
    chk(req, exp_out(), (pos != 0), !(fault_uv || fault_ot));
  endtask

  task automatic pulse(input int high_cycles);
    step_in = 1'b1; cyc(high_cycles);
    step_in = 1'b0; cyc(6);
  endtask

  task automatic do_step(input bit rev, input bit half);
    dir_in = rev; half_in = half; cyc(3);
    pulse(MINH + 3);
    if (xlat_rst_n && pwr_n) pos = next_pos(pos, rev, half);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    cyc(3);
    chk("R11 in reset", 4'b0101, 1'b0, 1'b1);
    rst = 1'b0; cyc(1);
    chk("R11 after reset", 4'b0101, 1'b0, 1'b1);
    cyc(4);
    chk("R11 settled", 4'b0101, 1'b0, 1'b1);

    // R4 full forward cycle, then reverse
    for (int i = 0; i < 4; i++) begin do_step(0, 0); chk_model("R4 full fwd"); end
    for (int i = 0; i < 4; i++) begin do_step(1, 0); chk_model("R4 full rev"); end
    // R5 half cycles
    for (int i = 0; i < 8; i++) begin do_step(0, 1); chk_model("R5 half fwd"); end
    for (int i = 0; i < 8; i++) begin do_step(1, 1); chk_model("R5 half rev"); end
    // R4 full step from single-winding position
    do_step(0, 1); chk("R5 pos1", 4'b0100, 1'b1, 1'b1);
    do_step(0, 0); chk("R4 odd start", 4'b0110, 1'b1, 1'b1);
    do_step(0, 1); do_step(1, 0); chk("R4 odd rev", 4'b0110, 1'b1, 1'b1);
    // R2 short pulse ignored
    pulse(MINH - 1); chk_model("R2 short pulse");
    pulse(MINH); pos = next_pos(pos, dir_in, half_in); chk_model("R2 min pulse");
    // R1 long high then falling: one step only
    pulse(40); pos = next_pos(pos, dir_in, half_in); chk_model("R1 single advance");
    // R3 direction flip inside window
    dir_in = 0; half_in = 1; cyc(3);
    step_in = 1'b1; cyc(1); dir_in = 1'b1; half_in = 1'b0; cyc(MINH + 3);
    step_in = 1'b0; cyc(6);
    pos = next_pos(pos, 0, 1); chk_model("R3 capture at edge");
    // R6 step while translator reset held
    xlat_rst_n = 1'b0; cyc(6); pos = 0;
    chk("R6 held", 4'b0000, 1'b0, 1'b1);
    do_step(0, 0); chk("R6 step ignored", 4'b0000, 1'b0, 1'b1);
    xlat_rst_n = 1'b1; cyc(6); chk("R6 release", 4'b0101, 1'b0, 1'b1);
    // R8 enable blanks, position kept
    enable = 1'b0; cyc(6);
    do_step(0, 0); do_step(0, 1); chk_model("R8 blanked");
    enable = 1'b1; cyc(6); chk("R8 resume", 4'b0010, 1'b1, 1'b1);
    // R10 fault with step during it
    fault_ot = 1'b1; cyc(6); do_step(1, 1); chk_model("R10 fault");
    fault_ot = 1'b0; cyc(6); chk("R10 clear", 4'b0110, 1'b1, 1'b1);
    // R7 power-down
    pwr_n = 1'b0; cyc(6); pos = 0; chk("R7 pd", 4'b0000, 1'b0, 1'b1);
    pwr_n = 1'b1; cyc(6); chk("R9 origin", 4'b0101, 1'b0, 1'b1);

    // Constrained random mix
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 19);
      if (op < 12) begin
        do_step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        chk_model("R1 random step");
      end else if (op < 14) begin
        enable = ~enable; cyc(6); chk_model("R8 random enable");
      end else if (op == 14) begin
        fault_uv = ~fault_uv; cyc(6); chk_model("R10 random fault");
      end else if (op == 15) begin
        xlat_rst_n = 1'b0; cyc(6); pos = 0; chk_model("R6 random reset");
        xlat_rst_n = 1'b1; cyc(6); chk_model("R6 random release");
      end else if (op == 16) begin
        pwr_n = 1'b0; cyc(6); pos = 0; chk_model("R7 random pd");
        pwr_n = 1'b1; cyc(6); chk_model("R7 random release");
      end else begin
        pulse($urandom_range(1, MINH - 1)); chk_model("R2 random glitch");
      end
      if (origin_n !== (pos != 0)) begin
        checks++; fails++;
        $display("FAIL R9: origin_n=%b expected %b", origin_n, (pos != 0));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule